// File: doc/BRIEF.md
# Banked GPIO Interrupt Controller

This block manages a 16-pin general-purpose I/O port through a byte-wide register window. Each pin has five configuration bits: direction, output level, output release (high impedance), interrupt enable and interrupt polarity. The bits are held in five byte registers. A bank-select bit in a control register decides which half of the port those registers reach. With bank 0 a register access touches pins 7:0. With bank 1 it touches pins 15:8.

For each pin the block drives an output value and an output enable toward the pad. It also produces one level-sensitive interrupt, which is the OR over every input pin whose enable is set and whose synchronized level matches its polarity. Pin inputs pass through a two-flop synchronizer before they reach the interrupt logic or the readback path. The interrupt needs no clearing: it stays high exactly as long as a qualifying pin condition holds.

Register map (3-bit address): 0 = control (bit 1 is the bank select; other bits read 0), 1 = direction, 2 = level, 3 = release, 4 = interrupt enable, 5 = polarity. Addresses 6 and 7 are reserved. Writes take effect at the rising clock edge while the write strobe is high. Read data is combinational from the address.

Top module: `gpio_bank_irq`

## Requirements
- R1: After reset the direction register reads 0xFF in both banks. Every other register, including the bank select, reads 0. In this state pinOe is 0 and irqOut is 0.
- R2: Control bit 1 selects the bank. A register write or read reaches pins 7:0 when that bit is 0 and pins 15:8 when it is 1. A write never changes the other bank.
- R3: A direction bit of 1 makes the pin an input and a bit of 0 makes it an output. pinOe for a pin is 1 only when its direction bit is 0 and its release bit is 0.
- R4: pinOut carries the level register bits for all 16 pins.
- R5: A release bit of 1 drops pinOe for that pin even while the pin is an output. A release bit of 0 lets an output pin drive.
- R6: irqOut is 1 when any input pin has its enable bit set and a synchronized level equal to its polarity bit. Polarity 1 means the pin is active while high, and polarity 0 means it is active while low.
- R7: A pin set as an output never raises irqOut, whatever its enable, polarity or input level.
- R8: Reading the level register returns, within the selected bank, the synchronized input value for input pins and the written level for output pins.
- R9: A change on pinIn reaches irqOut and the level readback on the second rising clock edge after it, not on the first.
- R10: irqOut is level-sensitive. It falls once no pin qualifies, with no clearing access.
- R11: Writes to reserved addresses 6 and 7 change no register, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Register address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr |
| pinIn | input | 16 | Raw pin input levels |
| pinOut | output | 16 | Output level per pin |
| pinOe | output | 16 | Output enable per pin |
| irqOut | output | 1 | Combined level interrupt |

## Verification
The bench goes after the bank boundary. A design that decodes the bank bit wrongly, or writes both halves at once, shows up as a corrupted byte when the other bank is read back. It times the synchronizer exactly, so a design with one flop fewer or one more raises the interrupt a cycle early or late. It also sets output pins whose enable and polarity would otherwise qualify, which catches a design that forgets to gate the interrupt with direction. Reserved-address writes and release bits on output pins are mixed into random traffic, so a decoder that aliases addresses 6 and 7, or an enable that ignores the release bit, produces a readback or pinOe mismatch.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 3'd0,
    REG_DIR  = 3'd1,
    REG_LVL  = 3'd2,
    REG_HIZ  = 3'd3,
    REG_IEN  = 3'd4,
    REG_POL  = 3'd5
  } regAddrE;

  // Strobes from the decoder to the register datapath
  typedef struct packed {
    logic    wrDir;
    logic    wrLvl;
    logic    wrHiz;
    logic    wrIen;
    logic    wrPol;
    logic    rdCtrl;
    regAddrE rdSel;
  } gpioStrobeT;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int BANK_IDX_W = 1,
  parameter int BANK_LSB   = 1,
  parameter int DATA_W     = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWrEn,
  input  logic [BANK_IDX_W-1:0] bankWrData,
  output gpioStrobeT            strobe,
  output logic [BANK_IDX_W-1:0] bankIdx,
  output logic [DATA_W-1:0]     ctrlRead
);

  logic [BANK_IDX_W-1:0] bankReg;
  logic                  wrCtrl;

  always_comb begin
    strobe        = '0;
    strobe.rdSel  = regAddrE'(busAddr);
    strobe.rdCtrl = (busAddr == REG_CTRL);
    wrCtrl        = 1'b0;
    if (busWrEn) begin
      unique case (busAddr)
        REG_CTRL: wrCtrl       = 1'b1;
        REG_DIR:  strobe.wrDir = 1'b1;
        REG_LVL:  strobe.wrLvl = 1'b1;
        REG_HIZ:  strobe.wrHiz = 1'b1;
        REG_IEN:  strobe.wrIen = 1'b1;
        REG_POL:  strobe.wrPol = 1'b1;
        default:  wrCtrl       = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bankReg <= '0;
    else if (wrCtrl) bankReg <= bankWrData;
  end

  assign bankIdx = bankReg;

  always_comb begin
    ctrlRead = '0;
    ctrlRead[BANK_LSB +: BANK_IDX_W] = bankReg;
  end

  // R2: at most one register is written per access
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrDir, strobe.wrLvl, strobe.wrHiz, strobe.wrIen, strobe.wrPol}));

  // R11: a reserved address leaves the bank select untouched
  a_r11_reserved_keeps_bank: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr > ADDR_W'(REG_POL)) |=> $stable(bankReg));

endmodule

// File: rtl/gpio_bank_datapath.sv
module gpio_bank_datapath
  import gpio_bank_pkg::*;
#(
  parameter int PIN_COUNT   = 16,
  parameter int BANK_WIDTH  = 8,
  parameter int NUM_BANKS   = 2,
  parameter int BANK_IDX_W  = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  gpioStrobeT            strobe,
  input  logic [BANK_IDX_W-1:0] bankIdx,
  input  logic [BANK_WIDTH-1:0] wrData,
  input  logic [PIN_COUNT-1:0]  pinIn,
  output logic [BANK_WIDTH-1:0] dpRead,
  output logic [PIN_COUNT-1:0]  pinOut,
  output logic [PIN_COUNT-1:0]  pinOe,
  output logic                  irqOut
);

  logic [PIN_COUNT-1:0] dirReg, lvlReg, hizReg, ienReg, polReg;
  logic [PIN_COUNT-1:0] syncStage [SYNC_STAGES];
  logic [PIN_COUNT-1:0] syncIn;
  logic [PIN_COUNT-1:0] levelView;
  logic [PIN_COUNT-1:0] pinActive;

  // One register set per bank; each bank only listens to its own index
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [BANK_WIDTH-1:0] dirR, lvlR, hizR, ienR, polR;
    logic                  hit;
    assign hit = (bankIdx == BANK_IDX_W'(b));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dirR <= '1;
        lvlR <= '0;
        hizR <= '0;
        ienR <= '0;
        polR <= '0;
      end else if (hit) begin
        if (strobe.wrDir) dirR <= wrData;
        if (strobe.wrLvl) lvlR <= wrData;
        if (strobe.wrHiz) hizR <= wrData;
        if (strobe.wrIen) ienR <= wrData;
        if (strobe.wrPol) polR <= wrData;
      end
    end

    assign dirReg[b*BANK_WIDTH +: BANK_WIDTH] = dirR;
    assign lvlReg[b*BANK_WIDTH +: BANK_WIDTH] = lvlR;
    assign hizReg[b*BANK_WIDTH +: BANK_WIDTH] = hizR;
    assign ienReg[b*BANK_WIDTH +: BANK_WIDTH] = ienR;
    assign polReg[b*BANK_WIDTH +: BANK_WIDTH] = polR;
  end

  // Input synchronizer chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncStage[s] <= '0;
    end else begin
      syncStage[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncStage[s] <= syncStage[s-1];
    end
  end

  assign syncIn = syncStage[SYNC_STAGES-1];

  // Pad-side outputs
  assign pinOut = lvlReg;
  assign pinOe  = ~dirReg & ~hizReg;

  // Level interrupt
  assign pinActive = dirReg & ienReg & ~(syncIn ^ polReg);
  assign irqOut    = |pinActive;

  // Level readback mixes synchronized inputs and written outputs
  assign levelView = (dirReg & syncIn) | (~dirReg & lvlReg);

  always_comb begin
    unique case (strobe.rdSel)
      REG_DIR: dpRead = dirReg[bankIdx*BANK_WIDTH +: BANK_WIDTH];
      REG_LVL: dpRead = levelView[bankIdx*BANK_WIDTH +: BANK_WIDTH];
      REG_HIZ: dpRead = hizReg[bankIdx*BANK_WIDTH +: BANK_WIDTH];
      REG_IEN: dpRead = ienReg[bankIdx*BANK_WIDTH +: BANK_WIDTH];
      REG_POL: dpRead = polReg[bankIdx*BANK_WIDTH +: BANK_WIDTH];
      default: dpRead = '0;
    endcase
  end

  // Cycles since reset, saturating, to guard the synchronizer check
  logic [1:0] upCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  // R2: a write to bank 0 leaves the upper bank untouched
  if (NUM_BANKS > 1) begin : g_bank_chk
    a_r2_other_bank_stable: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wrDir && bankIdx == '0) |=>
        dirReg[PIN_COUNT-1:BANK_WIDTH] == $past(dirReg[PIN_COUNT-1:BANK_WIDTH]));
  end

  // R4: a level write lands in the selected bank
  a_r4_level_write: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrLvl |=> lvlReg[$past(bankIdx)*BANK_WIDTH +: BANK_WIDTH] == $past(wrData));

  // R6: with no enables there is no interrupt
  a_r6_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rstN)
    (ienReg == '0) |-> !irqOut);

  // R9: synchronized input equals the raw input two edges back
  if (SYNC_STAGES == 2) begin : g_sync_chk
    a_r9_sync_latency: assert property (@(posedge clk) disable iff (!rstN)
      (upCnt >= 2'd2) |-> syncIn == $past(pinIn, 2));
  end

endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
  import gpio_bank_pkg::*;
#(
  parameter int PIN_COUNT   = 16,
  parameter int BANK_WIDTH  = 8,
  parameter int BANK_LSB    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [2:0]            busAddr,
  input  logic                  busWrEn,
  input  logic [BANK_WIDTH-1:0] busWrData,
  output logic [BANK_WIDTH-1:0] busRdData,
  input  logic [PIN_COUNT-1:0]  pinIn,
  output logic [PIN_COUNT-1:0]  pinOut,
  output logic [PIN_COUNT-1:0]  pinOe,
  output logic                  irqOut
);

  localparam int NUM_BANKS  = PIN_COUNT / BANK_WIDTH;
  localparam int BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  gpioStrobeT            strobe;
  logic [BANK_IDX_W-1:0] bankIdx;
  logic [BANK_WIDTH-1:0] ctrlRead;
  logic [BANK_WIDTH-1:0] dpRead;

  gpio_bank_ctrl #(
    .BANK_IDX_W(BANK_IDX_W),
    .BANK_LSB  (BANK_LSB),
    .DATA_W    (BANK_WIDTH)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .bankWrData(busWrData[BANK_LSB +: BANK_IDX_W]),
    .strobe    (strobe),
    .bankIdx   (bankIdx),
    .ctrlRead  (ctrlRead)
  );

  gpio_bank_datapath #(
    .PIN_COUNT  (PIN_COUNT),
    .BANK_WIDTH (BANK_WIDTH),
    .NUM_BANKS  (NUM_BANKS),
    .BANK_IDX_W (BANK_IDX_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .bankIdx(bankIdx),
    .wrData (busWrData),
    .pinIn  (pinIn),
    .dpRead (dpRead),
    .pinOut (pinOut),
    .pinOe  (pinOe),
    .irqOut (irqOut)
  );

  assign busRdData = strobe.rdCtrl ? ctrlRead : dpRead;

endmodule

// File: tb/gpio_bank_irq_tb.sv
module gpio_bank_irq_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic [15:0] pinIn = '0;
  logic [15:0] pinOut, pinOe;
  logic        irqOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Bench model
  logic [15:0] mDir = 16'hFFFF, mLvl = '0, mHiz = '0, mIen = '0, mPol = '0;
  logic        mBank = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank_irq u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

  function automatic logic [15:0] expOe();
    return ~mDir & ~mHiz;
  endfunction

  function automatic logic expIrq();
    return |(mDir & mIen & ~(pinIn ^ mPol));
  endfunction

  function automatic logic [7:0] expRead(logic [2:0] a);
    logic [15:0] lv;
    lv = (mDir & pinIn) | (~mDir & mLvl);
    case (a)
      3'd0: return {6'b0, mBank, 1'b0};
      3'd1: return mDir[mBank*8 +: 8];
      3'd2: return lv[mBank*8 +: 8];
      3'd3: return mHiz[mBank*8 +: 8];
      3'd4: return mIen[mBank*8 +: 8];
      3'd5: return mPol[mBank*8 +: 8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    case (a)
      3'd0: mBank = d[1];
      3'd1: mDir[mBank*8 +: 8] = d;
      3'd2: mLvl[mBank*8 +: 8] = d;
      3'd3: mHiz[mBank*8 +: 8] = d;
      3'd4: mIen[mBank*8 +: 8] = d;
      3'd5: mPol[mBank*8 +: 8] = d;
      default: ;
    endcase
  endtask

  task automatic rdChk(string req, logic [2:0] a);
    busAddr = a;
    #1;
    chk(req, busRdData, expRead(a));
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic allChk(string req);
    chk({req, " oe"}, pinOe, expOe());
    chk({req, " out"}, pinOut, mLvl);
    chk({req, " irq"}, irqOut, expIrq());
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    // R1: state during and after reset
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", pinOe, 16'h0);
    chk("R1 irq in reset", irqOut, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 8; a++) rdChk("R1 bank0 read", 3'(a));
    wrReg(3'd0, 8'h02);
    for (int a = 0; a < 8; a++) rdChk("R1 bank1 read", 3'(a));
    wrReg(3'd0, 8'h00);

    // R2: bank isolation
    wrReg(3'd0, 8'h02);
    wrReg(3'd1, 8'h00);
    rdChk("R2 bank1 dir", 3'd1);
    wrReg(3'd0, 8'h00);
    rdChk("R2 bank0 dir untouched", 3'd1);
    chk("R2 oe upper only", pinOe, 16'hFF00);

    // R3 R4 R5: outputs and release
    wrReg(3'd2, 8'hA5);
    wrReg(3'd1, 8'h0F);
    wrReg(3'd3, 8'h30);
    allChk("R3 R5 drive mix");
    chk("R4 out", pinOut[7:0], 8'hA5);
    chk("R5 released pins", pinOe[7:0], 8'hC0);

    // R9 R6 R10: synchronizer timing and level irq on pin 15 (bank 1)
    wrReg(3'd0, 8'h02);
    wrReg(3'd1, 8'hFF);
    wrReg(3'd4, 8'h80);
    wrReg(3'd5, 8'h80);
    pinIn = '0;
    settle();
    chk("R6 idle irq", irqOut, 1'b0);
    pinIn[15] = 1'b1;
    @(negedge clk);
    chk("R9 one edge no irq", irqOut, 1'b0);
    busAddr = 3'd2; #1;
    chk("R9 one edge readback old", busRdData[7], 1'b0);
    @(negedge clk);
    chk("R9 two edges irq", irqOut, 1'b1);
    busAddr = 3'd2; #1;
    chk("R9 two edges readback", busRdData[7], 1'b1);
    pinIn[15] = 1'b0;
    settle();
    chk("R10 irq falls", irqOut, 1'b0);
    wrReg(3'd5, 8'h00);
    settle();
    chk("R6 low polarity", irqOut, 1'b1);

    // R7: output pin never interrupts
    wrReg(3'd1, 8'h7F);
    settle();
    chk("R7 output pin irq", irqOut, 1'b0);

    // R8: level readback mix
    pinIn[14:8] = 7'h55;
    settle();
    rdChk("R8 level mix", 3'd2);

    // R11: reserved addresses
    wrReg(3'd6, 8'hFF);
    wrReg(3'd7, 8'h00);
    for (int a = 0; a < 8; a++) rdChk("R11 reserved", 3'(a));
    allChk("R11 outputs");

    // Random traffic
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        pinIn = 16'($urandom);
      end else begin
        wrReg(3'($urandom_range(0, 7)), 8'($urandom));
      end
      settle();
      allChk("R3 R6 random");
      rdChk("R2 R8 random read", 3'($urandom_range(0, 7)));
    end

    finishRun();
  end

endmodule